// File: doc/BRIEF.md
# Programmable Clamp and Sample Pulse Generator

This block produces the two timing strobes of a dual-mode imaging front end: a clamp strobe that marks the reference level of each pixel and a sample strobe that marks the video level. It runs on a fast clock at 64 times the pixel rate. It splits every pixel period into 64 phase slots with a 6-bit slot counter, and that counter is realigned to the rising edge of the pixel clock after a synchronizer. Each strobe has a programmable first slot and last slot. A first slot above the last slot gives a strobe that crosses the period boundary and ends in the next period.

A small write-only register port holds both slot pairs, the operating mode and a monitor selector. In sample-and-hold mode, which is selected after reset, only the sample pair has any effect and the clamp strobe stays low. In correlated-double-sampling mode both pairs are live. Register writes go into staging copies. Those copies move into the working copies only when the slot counter passes slot 0, so a strobe is never changed in the middle of a period. The monitor selector can route both strobes to two debug pins.

Top module: `pulse_timing_gen`

## Requirements
- R1: `slot_idx` advances by one, modulo 64, on every fast clock edge. When the pixel clock rises, `slot_idx` reads 0 after the third fast clock edge that follows the rise, whatever its value was before.
- R2: When first slot ≤ last slot, `sample_out` is high exactly in slots first..last inclusive. The sample first slot is at address 0x22 and the sample last slot is at address 0x23, each in `wr_data[5:0]`.
- R3: When first slot > last slot, `sample_out` is high from the first slot through slot 63 and again from slot 0 through the last slot.
- R4: When first slot = last slot, the strobe is high for exactly one slot.
- R5: In sample-and-hold mode (address 0x08, `wr_data[0]` = 0), `clamp_out` stays 0 whatever the clamp registers hold.
- R6: In correlated-double-sampling mode (address 0x08, `wr_data[0]` = 1), `clamp_out` follows the window rule of R2/R3, using the clamp first slot at address 0x20 and the clamp last slot at address 0x21.
- R7: While reset is held, `slot_idx` is 0 and all strobe and debug outputs are 0. After reset the block is in sample-and-hold mode, the monitor field is 00, the sample window is 16..31 and the clamp window is 48..55.
- R8: When the monitor field (address 0x09, `wr_data[4:3]`) holds binary 10, `dbg1_out` equals `sample_out` and `dbg0_out` equals `clamp_out`.
- R9: For any other monitor field value, both debug outputs are 0.
- R10: A window or mode write takes effect at slot 0 of the next period. The strobes keep the old settings for the remainder of the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, 64 times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, asynchronous to clk_fast |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| slot_idx | output | 6 | Current phase slot |
| clamp_out | output | 1 | Clamp strobe, registered |
| sample_out | output | 1 | Sample strobe, registered |
| dbg0_out | output | 1 | Debug pin 0 (clamp when the monitor field is 10) |
| dbg1_out | output | 1 | Debug pin 1 (sample when the monitor field is 10) |

## Verification
A slot counter that slips or realigns late moves both strobes by the same number of slots. It shows within one period, because `slot_idx` fails to read 0 three edges after a pixel-clock rise. A working window that is loaded early or late shows up as a strobe edge in the wrong slot. The bench looks for this in the tail of the period in which the write lands and again in the first slots of the next period. A mode copy that is wrong shows up as a clamp strobe in sample-and-hold mode, or as a missing clamp strobe in the other mode, within one period.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int SLOT_W   = 6;
  localparam int NSLOT    = 1 << SLOT_W;
  localparam int NCH      = 2;            // 0 = clamp, 1 = sample
  localparam int CH_CLAMP = 0;
  localparam int CH_SMP   = 1;

  localparam logic [7:0] ADDR_WIN_BASE = 8'h20;  // first/last pairs, clamp then sample
  localparam logic [7:0] ADDR_MODE     = 8'h08;
  localparam logic [7:0] ADDR_MON      = 8'h09;
  localparam int         MON_LSB       = 3;
  localparam logic [1:0] MON_PULSES    = 2'b10;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    slot_t first;
    slot_t last;
  } win_t;

  function automatic win_t win_reset(input int ch);
    win_t w;
    if (ch == CH_SMP) begin
      w.first = slot_t'(16);
      w.last  = slot_t'(31);
    end else begin
      w.first = slot_t'(48);
      w.last  = slot_t'(55);
    end
    return w;
  endfunction

  // Inclusive window membership; first > last wraps across the period boundary.
  function automatic logic slot_in_win(input slot_t s, input win_t w);
    if (w.first <= w.last) return (s >= w.first) && (s <= w.last);
    else                   return (s >= w.first) || (s <= w.last);
  endfunction
endpackage

// File: rtl/pgen_sync_edge.sv
module pgen_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_evt
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_evt = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pgen_phase_ctr.sv
module pgen_phase_ctr
  import pgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_evt,
  output slot_t slot_q,
  output slot_t slot_nxt,
  output logic  load_evt
);
  localparam slot_t LAST_SLOT = slot_t'(NSLOT - 1);

  assign slot_nxt = rise_evt ? '0 : slot_q + slot_t'(1);
  assign load_evt = rise_evt || (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_nxt;
  end
endmodule

// File: rtl/pgen_regs.sv
module pgen_regs
  import pgen_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_evt,
  output win_t              win_nxt [NCH],
  output win_t              win_act [NCH],
  output logic              cds_nxt,
  output logic              cds_act,
  output logic [1:0]        mon_sel
);
  win_t stg_q [NCH];
  logic cds_stg_q;

  logic unused_wr;
  assign unused_wr = ^wr_data;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(ADDR_WIN_BASE + 8'(2 * c));
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(ADDR_WIN_BASE + 8'(2 * c + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_q[c] <= win_reset(c);
      end else if (wr_en) begin
        if (wr_addr == A_FIRST) stg_q[c].first <= wr_data[SLOT_W-1:0];
        if (wr_addr == A_LAST)  stg_q[c].last  <= wr_data[SLOT_W-1:0];
      end
    end

    assign win_nxt[c] = load_evt ? stg_q[c] : win_act[c];

    always_ff @(posedge clk) begin
      if (!rst_n) win_act[c] <= win_reset(c);
      else        win_act[c] <= win_nxt[c];
    end
  end

  assign cds_nxt = load_evt ? cds_stg_q : cds_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cds_stg_q <= 1'b0;
      cds_act   <= 1'b0;
      mon_sel   <= 2'b00;
    end else begin
      cds_act <= cds_nxt;
      if (wr_en && wr_addr == ADDR_W'(ADDR_MODE)) cds_stg_q <= wr_data[0];
      if (wr_en && wr_addr == ADDR_W'(ADDR_MON))  mon_sel   <= wr_data[MON_LSB+1:MON_LSB];
    end
  end
endmodule

// File: rtl/pgen_window.sv
module pgen_window
  import pgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  slot_t slot_nxt,
  input  win_t  win,
  output logic  pulse_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= enable && slot_in_win(slot_nxt, win);
  end
endmodule

// File: rtl/pulse_timing_gen.sv
module pulse_timing_gen
  import pgen_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              clamp_out,
  output logic              sample_out,
  output logic              dbg0_out,
  output logic              dbg1_out
);
  logic  edge_evt;
  logic  load_evt;
  slot_t slot_q;
  slot_t slot_nxt;
  win_t  win_nxt [NCH];
  win_t  win_act [NCH];
  logic  cds_nxt;
  logic  cds_act;
  logic [1:0] mon_sel;
  logic [NCH-1:0] pulse;
  logic [NCH-1:0] ch_en;
  win_t  smp_win;

  pgen_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_fast), .rst_n(rst_n), .async_in(pix_clk), .rise_evt(edge_evt)
  );

  pgen_phase_ctr u_ctr (
    .clk(clk_fast), .rst_n(rst_n), .rise_evt(edge_evt),
    .slot_q(slot_q), .slot_nxt(slot_nxt), .load_evt(load_evt)
  );

  pgen_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk_fast), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_evt(load_evt), .win_nxt(win_nxt),
    .win_act(win_act), .cds_nxt(cds_nxt), .cds_act(cds_act), .mon_sel(mon_sel)
  );

  assign ch_en[CH_CLAMP] = cds_nxt;
  assign ch_en[CH_SMP]   = 1'b1;

  for (genvar c = 0; c < NCH; c++) begin : g_win
    pgen_window u_win (
      .clk(clk_fast), .rst_n(rst_n), .enable(ch_en[c]),
      .slot_nxt(slot_nxt), .win(win_nxt[c]), .pulse_q(pulse[c])
    );
  end

  assign smp_win    = win_act[CH_SMP];
  assign slot_idx   = slot_q;
  assign clamp_out  = pulse[CH_CLAMP];
  assign sample_out = pulse[CH_SMP];
  assign dbg0_out   = (mon_sel == MON_PULSES) ? pulse[CH_CLAMP] : 1'b0;
  assign dbg1_out   = (mon_sel == MON_PULSES) ? pulse[CH_SMP]   : 1'b0;
endmodule

// File: rtl/pgen_checker.sv
module pgen_checker
  import pgen_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       edge_evt,
  input logic       load_evt,
  input slot_t      slot_idx,
  input win_t       smp_win,
  input logic       cds_act,
  input logic [1:0] mon_sel,
  input logic       clamp_out,
  input logic       sample_out,
  input logic       dbg0_out,
  input logic       dbg1_out
);
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_evt |=> slot_idx == slot_t'($past(slot_idx) + slot_t'(1))); // R1
  AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> slot_idx == '0); // R1
  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sample_out) && smp_win.first == smp_win.last && !load_evt) |=> !sample_out); // R4
  AST_SH_NO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    !cds_act |-> !clamp_out); // R5
  AST_MON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mon_sel != MON_PULSES |-> !dbg0_out && !dbg1_out); // R9
  AST_WIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(smp_win) && $stable(cds_act)); // R10
endmodule

bind pulse_timing_gen pgen_checker u_chk (
  .clk(clk_fast), .rst_n(rst_n), .edge_evt(edge_evt), .load_evt(load_evt),
  .slot_idx(slot_q), .smp_win(smp_win), .cds_act(cds_act), .mon_sel(mon_sel),
  .clamp_out(clamp_out), .sample_out(sample_out), .dbg0_out(dbg0_out),
  .dbg1_out(dbg1_out)
);

// File: tb/pulse_timing_gen_bench.sv
`timescale 1ns/1ps
module pulse_timing_gen_bench;
  logic       clk_fast = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] slot_idx;
  logic       clamp_out, sample_out, dbg0_out, dbg1_out;

  int n_vec = 0;
  int n_bad = 0;
  logic [5:0] pcnt = '0;

  // model of the programmed settings (active copy)
  logic [5:0] m_sf = 6'd16, m_sl = 6'd31, m_cf = 6'd48, m_cl = 6'd55;
  logic       m_cds = 1'b0;
  logic [1:0] m_mon = 2'b00;

  pulse_timing_gen u_pulse_timing_gen (
    .clk_fast(clk_fast), .rst_n(rst_n), .pix_clk(pix_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .slot_idx(slot_idx),
    .clamp_out(clamp_out), .sample_out(sample_out), .dbg0_out(dbg0_out),
    .dbg1_out(dbg1_out)
  );

  always #2 clk_fast = ~clk_fast;  // 250 MHz

  // pixel clock: 64 fast cycles per period, half high
  always @(posedge clk_fast) begin
    pcnt    <= pcnt + 6'd1;
    pix_clk <= (pcnt == 6'd63) ? 1'b1 : (pcnt == 6'd31) ? 1'b0 : pix_clk;
  end

  function automatic logic exp_win(input logic [5:0] s, input logic [5:0] a, input logic [5:0] b);
    logic [5:0] off, span;
    off  = s - a;
    span = b - a;
    return off <= span;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s slot=%0d actual=%0d expected=%0d", tag, slot_idx, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_fast);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_fast);
    wr_en = 1'b0;
  endtask

  task automatic to_period_start();
    @(negedge clk_fast);
    while (slot_idx != 6'd0) @(negedge clk_fast);
  endtask

  // compare n consecutive slots against the model, one negedge apart
  task automatic check_slots(input int n, input string stag);
    logic [5:0] prev;
    logic e_s, e_c;
    for (int k = 0; k < n; k++) begin
      if (k > 0) check(slot_idx == prev + 6'd1, "R1", slot_idx, prev + 6'd1);
      e_s = exp_win(slot_idx, m_sf, m_sl);
      e_c = m_cds && exp_win(slot_idx, m_cf, m_cl);
      check(sample_out == e_s, stag, sample_out, e_s);
      check(clamp_out == e_c, m_cds ? "R6" : "R5", clamp_out, e_c);
      check(dbg1_out == ((m_mon == 2'b10) && e_s), (m_mon == 2'b10) ? "R8" : "R9", dbg1_out, (m_mon == 2'b10) && e_s);
      check(dbg0_out == ((m_mon == 2'b10) && e_c), (m_mon == 2'b10) ? "R8" : "R9", dbg0_out, (m_mon == 2'b10) && e_c);
      prev = slot_idx;
      @(negedge clk_fast);
    end
  endtask

  task automatic set_sample(input logic [5:0] f, input logic [5:0] l);
    reg_wr(8'h22, {2'b00, f});
    reg_wr(8'h23, {2'b00, l});
    m_sf = f; m_sl = l;
  endtask

  task automatic set_clamp(input logic [5:0] f, input logic [5:0] l);
    reg_wr(8'h20, {2'b00, f});
    reg_wr(8'h21, {2'b00, l});
    m_cf = f; m_cl = l;
  endtask

  task automatic t_reset();  // R7
    @(negedge clk_fast);
    check(slot_idx == 6'd0, "R7", slot_idx, 0);
    check(!sample_out && !clamp_out, "R7", sample_out | clamp_out, 0);
    check(!dbg0_out && !dbg1_out, "R7", dbg0_out | dbg1_out, 0);
  endtask

  task automatic t_defaults();  // R7: default window 16..31, sample-and-hold
    to_period_start();
    check_slots(64, "R7");
  endtask

  task automatic t_plain();  // R2
    set_sample(6'd5, 6'd40);
    to_period_start();
    check_slots(64, "R2");
  endtask

  task automatic t_wrap();  // R3
    set_sample(6'd50, 6'd9);
    to_period_start();
    check_slots(64, "R3");
  endtask

  task automatic t_single();  // R4
    set_sample(6'd33, 6'd33);
    to_period_start();
    check_slots(64, "R4");
    set_sample(6'd63, 6'd63);
    to_period_start();
    check_slots(64, "R4");
    set_sample(6'd0, 6'd0);
    to_period_start();
    check_slots(64, "R4");
  endtask

  task automatic t_sh_clamp();  // R5: clamp registers have no effect
    set_clamp(6'd2, 6'd12);
    set_sample(6'd20, 6'd45);
    to_period_start();
    check_slots(64, "R5");
  endtask

  task automatic t_cds();  // R6
    reg_wr(8'h08, 8'h01);
    m_cds = 1'b1;
    to_period_start();
    check_slots(64, "R6");
    set_clamp(6'd60, 6'd3);
    to_period_start();
    check_slots(64, "R6");
  endtask

  task automatic t_monitor();  // R8, R9
    reg_wr(8'h09, 8'h10);
    m_mon = 2'b10;
    to_period_start();
    check_slots(64, "R8");
    reg_wr(8'h09, 8'h08);
    m_mon = 2'b01;
    to_period_start();
    check_slots(64, "R9");
    reg_wr(8'h09, 8'h18);
    m_mon = 2'b11;
    to_period_start();
    check_slots(64, "R9");
    reg_wr(8'h09, 8'h10);
    m_mon = 2'b10;
  endtask

  task automatic t_midperiod();  // R10
    to_period_start();
    while (slot_idx != 6'd20) @(negedge clk_fast);
    reg_wr(8'h22, 8'd40);
    reg_wr(8'h23, 8'd50);
    reg_wr(8'h08, 8'h00);
    check_slots(36, "R10");  // rest of this period still uses old settings
    m_sf = 6'd40; m_sl = 6'd50; m_cds = 1'b0;
    to_period_start();
    check_slots(64, "R10");
  endtask

  task automatic wait_rise_check(input string tag);
    logic prev;
    prev = pix_clk;
    @(negedge clk_fast);
    while (!(pix_clk && !prev)) begin
      prev = pix_clk;
      @(negedge clk_fast);
    end
    repeat (3) @(negedge clk_fast);
    check(slot_idx == 6'd0, tag, slot_idx, 0);
  endtask

  task automatic t_realign();  // R1
    wait_rise_check("R1");
    @(negedge clk_fast);
    pcnt = pcnt + 6'd21;
    wait_rise_check("R1");
    check_slots(64, "R1");
  endtask

  initial begin
    #(200000 * 4);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk_fast);
    t_reset();
    rst_n = 1'b1;
    t_realign();
    t_defaults();
    t_plain();
    t_wrap();
    t_single();
    t_sh_clamp();
    t_cds();
    t_monitor();
    t_midperiod();
    t_realign();
    summary();
  end
endmodule